// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Encoder

This block produces the on/off envelope of a 32-bit pulse-distance infrared remote-control frame. A downstream carrier generator uses the `mark_o` output as its gate. It only modulates the carrier while `mark_o` is high. A key-scan controller supplies three values: a custom byte, a second custom byte and a data byte. It then pulses `start_i` for one cycle. The encoder latches the three bytes and sends a full frame. While `key_held_i` stays high it follows that frame with short repeat frames at a fixed cadence.

All durations are counted in ticks. One tick lasts `CLK_HZ/TICK_HZ` clock cycles. Every duration is rounded to the nearest whole tick. With the default 16 ticks per millisecond, the durations are:

| Part of the frame | Ticks |
|---|---|
| Leader mark | 144 |
| Full leader space | 72 |
| Repeat leader space | 36 |
| Data mark | 9 |
| Space after a 0 bit | 9 |
| Space after a 1 bit | 27 |
| Frame cadence | 1728 |

The tick divider restarts on an accepted start strobe. Each segment therefore lasts exactly its tick count times the divider.

Top module: `irfe_encoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `mark_o` and `busy_o` are both low.
- R2: An accepted start raises `mark_o` in the next cycle. A full frame then opens with a 9 ms mark (144 ticks) and a 4.5 ms space (72 ticks), each exactly ticks × (CLK_HZ/TICK_HZ) cycles long.
- R3: A full frame carries 32 bits. Let the latched bytes be C (custom), S (second custom) and D (data). The frame sends, least-significant bit first, the 32-bit word {~D, D, S, C}: C first, then S, then D, then the bitwise complement of D.
- R4: Each bit opens with a 0.56 ms mark (9 ticks). The space after it is 9 ticks for a 0, giving a 1.125 ms bit, or 27 ticks for a 1, giving a 2.25 ms bit.
- R5: After the 32nd bit's space, a single stop mark of 9 ticks is sent and `mark_o` then returns low.
- R6: If `key_held_i` is high when 1728 ticks (108 ms) have passed since the start of the previous frame, a repeat frame begins at exactly that instant. A repeat frame is a 144-tick mark, a 36-tick space and a 9-tick stop mark, with no data bits.
- R7: If `key_held_i` is low at that 108 ms boundary, no further frame is sent. `busy_o` falls at that boundary and `mark_o` stays low.
- R8: `busy_o` rises only in the cycle after an accepted start. It stays high through every frame and gap until the release boundary of R7. `mark_o` is never high while `busy_o` is low. Start strobes and byte changes while `busy_o` is high have no effect on the frame being sent.
- R9: With `SECOND_FROM_INPUT` = 1, the second custom byte S is taken from `cust2_i`. With `SECOND_FROM_INPUT` = 0, S is the bitwise complement of the latched custom byte C, and `cust2_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to send a new frame; only honoured while idle |
| key_held_i | input | 1 | High while the key is still pressed; sampled at each 108 ms boundary |
| cust_i | input | BYTE_W | Custom byte C |
| cust2_i | input | BYTE_W | Second custom byte S, used when SECOND_FROM_INPUT = 1 |
| data_i | input | BYTE_W | Data byte D |
| mark_o | output | 1 | High during marks; gates the carrier |
| busy_o | output | 1 | High from an accepted start until the release boundary |

## Verification
The bench measures every mark and space run in clock cycles and compares each run with the expected tick count for the bit being sent. This catches several kinds of fault:
- Swapped byte order, MSB-first shifting or a missing data complement corrupts specific space lengths.
- An off-by-one in the segment counter shifts every run by one tick.

It also times each repeat leader against the start of the previous frame. A cadence measured from the end of the frame, or a period counter that is not cleared, would move that edge. The busy release is also checked at that same boundary. A start strobe with new bytes is injected in the middle of each frame. A design that re-latched these bytes would corrupt the remaining bits. A second instance checks the complemented second byte.

// File: rtl/irfe_pkg.sv
// Shared types and timing helpers for the pulse-distance IR frame encoder.
// Assumes durations are given in microseconds and converted with rounding.
package irfe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD_MARK,
        ST_LEAD_SPACE,
        ST_BIT_MARK,
        ST_BIT_SPACE,
        ST_STOP_MARK,
        ST_GAP
    } irfe_state_e;

    localparam int unsigned LEAD_MARK_US  = 9000;
    localparam int unsigned LEAD_SPACE_US = 4500;
    localparam int unsigned RPT_SPACE_US  = 2250;
    localparam int unsigned MARK_US       = 560;
    localparam int unsigned BIT0_US       = 1125;
    localparam int unsigned BIT1_US       = 2250;
    localparam int unsigned PERIOD_US     = 108000;

    // Convert a duration in microseconds to the nearest whole number of ticks.
    function automatic int unsigned us_to_ticks(input int unsigned us, input int unsigned tick_hz);
        longint unsigned prod;
        prod = longint'(us) * longint'(tick_hz) + 64'd500000;
        return int'(prod / 64'd1000000);
    endfunction

endpackage

// File: rtl/irfe_tick_gen.sv
// Tick divider: one-cycle tick every DIV clock cycles.
// Assumes restart is pulsed when a frame begins so segments align to ticks.
module irfe_tick_gen #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_every_cycle
            assign tick = 1'b1;
        end else begin : g_divide
            localparam int unsigned W = $clog2(DIV);
            logic [W-1:0] cnt;

            // Count clock cycles within one tick; restart clears the phase.
            always_ff @(posedge clk) begin
                if (!rst_n || restart) begin
                    cnt <= '0;
                end else if (cnt == W'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == W'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/irfe_payload.sv
// Payload shifter: latches the frame word and presents bits LSB first.
// Assumes load and shift never coincide.
module irfe_payload #(
    parameter int unsigned BYTE_W            = 8,
    parameter bit          SECOND_FROM_INPUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] cust,
    input  logic [BYTE_W-1:0] cust2,
    input  logic [BYTE_W-1:0] data,
    output logic              cur_bit
);

    localparam int unsigned NBITS = 4 * BYTE_W;

    logic [BYTE_W-1:0] second;
    logic [NBITS-1:0]  word_q;

    generate
        if (SECOND_FROM_INPUT) begin : g_second_in
            assign second = cust2;
        end else begin : g_second_inv
            assign second = ~cust;
        end
    endgenerate

    // Hold the 32-bit frame word and shift it one place per sent bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= {~data, data, second, cust};
        end else if (shift) begin
            word_q <= word_q >> 1;
        end
    end

    assign cur_bit = word_q[0];

endmodule

// File: rtl/irfe_seq.sv
// Frame sequencer: walks leader, data bits, stop mark and the gap to the
// next 108 ms boundary, and decides at that boundary whether to repeat.
// Assumes PERIOD_T exceeds the longest full frame in ticks.
module irfe_seq
    import irfe_pkg::*;
#(
    parameter int unsigned LEAD_T   = 144,
    parameter int unsigned LSP_T    = 72,
    parameter int unsigned RSP_T    = 36,
    parameter int unsigned MARK_T   = 9,
    parameter int unsigned SP0_T    = 9,
    parameter int unsigned SP1_T    = 27,
    parameter int unsigned PERIOD_T = 1728,
    parameter int unsigned NBITS    = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic key_held,
    input  logic cur_bit,
    output logic mark,
    output logic busy,
    output logic load,
    output logic shift
);

    localparam int unsigned CW = $clog2(PERIOD_T + 1);
    localparam int unsigned BW = $clog2(NBITS);

    irfe_state_e   state;
    logic [CW-1:0] seg_cnt;
    logic [CW-1:0] period_cnt;
    logic [CW-1:0] seg_len;
    logic [BW-1:0] bit_idx;
    logic          rpt;
    logic          start_ok;
    logic          seg_end;
    logic          boundary;
    logic          timed_seg;

    assign start_ok  = start && (state == ST_IDLE);
    assign timed_seg = (state != ST_IDLE) && (state != ST_GAP);
    assign seg_end   = tick && timed_seg && (seg_cnt == seg_len - 1'b1);
    assign boundary  = tick && (period_cnt == CW'(PERIOD_T - 1));

    // Pick the tick length of the segment now in progress.
    always_comb begin
        case (state)
            ST_LEAD_MARK:  seg_len = CW'(LEAD_T);
            ST_LEAD_SPACE: seg_len = rpt ? CW'(RSP_T) : CW'(LSP_T);
            ST_BIT_MARK:   seg_len = CW'(MARK_T);
            ST_BIT_SPACE:  seg_len = cur_bit ? CW'(SP1_T) : CW'(SP0_T);
            ST_STOP_MARK:  seg_len = CW'(MARK_T);
            default:       seg_len = CW'(PERIOD_T);
        endcase
    end

    // Segment and period tick counters, both cleared when a frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_cnt    <= '0;
            period_cnt <= '0;
        end else if (start_ok) begin
            seg_cnt    <= '0;
            period_cnt <= '0;
        end else if (state != ST_IDLE) begin
            if (tick) begin
                period_cnt <= boundary ? '0 : period_cnt + 1'b1;
            end
            if (seg_end || state == ST_GAP) begin
                seg_cnt <= '0;
            end else if (tick) begin
                seg_cnt <= seg_cnt + 1'b1;
            end
        end
    end

    // Frame state machine with the bit index and repeat flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            rpt     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state <= ST_LEAD_MARK;
                        rpt   <= 1'b0;
                    end
                end
                ST_LEAD_MARK: begin
                    if (seg_end) state <= ST_LEAD_SPACE;
                end
                ST_LEAD_SPACE: begin
                    if (seg_end) begin
                        state   <= rpt ? ST_STOP_MARK : ST_BIT_MARK;
                        bit_idx <= '0;
                    end
                end
                ST_BIT_MARK: begin
                    if (seg_end) state <= ST_BIT_SPACE;
                end
                ST_BIT_SPACE: begin
                    if (seg_end) begin
                        bit_idx <= bit_idx + 1'b1;
                        state   <= (bit_idx == BW'(NBITS - 1)) ? ST_STOP_MARK : ST_BIT_MARK;
                    end
                end
                ST_STOP_MARK: begin
                    if (seg_end) state <= ST_GAP;
                end
                ST_GAP: begin
                    if (boundary) begin
                        if (key_held) begin
                            state <= ST_LEAD_MARK;
                            rpt   <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mark  = (state == ST_LEAD_MARK) || (state == ST_BIT_MARK) || (state == ST_STOP_MARK);
    assign busy  = (state != ST_IDLE);
    assign load  = start_ok;
    assign shift = seg_end && (state == ST_BIT_SPACE);

endmodule

// File: rtl/irfe_encoder.sv
// Top of the pulse-distance IR frame encoder: tick divider, payload shifter
// and sequencer. Assumes CLK_HZ is an integer multiple of TICK_HZ.
module irfe_encoder
    import irfe_pkg::*;
#(
    parameter int unsigned CLK_HZ            = 16_000_000,
    parameter int unsigned TICK_HZ           = 16_000,
    parameter int unsigned BYTE_W            = 8,
    parameter bit          SECOND_FROM_INPUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              key_held_i,
    input  logic [BYTE_W-1:0] cust_i,
    input  logic [BYTE_W-1:0] cust2_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              mark_o,
    output logic              busy_o
);

    localparam int unsigned DIV      = CLK_HZ / TICK_HZ;
    localparam int unsigned NBITS    = 4 * BYTE_W;
    localparam int unsigned LEAD_T   = us_to_ticks(LEAD_MARK_US, TICK_HZ);
    localparam int unsigned LSP_T    = us_to_ticks(LEAD_SPACE_US, TICK_HZ);
    localparam int unsigned RSP_T    = us_to_ticks(RPT_SPACE_US, TICK_HZ);
    localparam int unsigned MARK_T   = us_to_ticks(MARK_US, TICK_HZ);
    localparam int unsigned SP0_T    = us_to_ticks(BIT0_US, TICK_HZ) - MARK_T;
    localparam int unsigned SP1_T    = us_to_ticks(BIT1_US, TICK_HZ) - MARK_T;
    localparam int unsigned PERIOD_T = us_to_ticks(PERIOD_US, TICK_HZ);

    logic tick;
    logic load;
    logic shift;
    logic cur_bit;

    irfe_tick_gen #(.DIV(DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .tick    (tick)
    );

    irfe_payload #(
        .BYTE_W            (BYTE_W),
        .SECOND_FROM_INPUT (SECOND_FROM_INPUT)
    ) u_payload (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .cust    (cust_i),
        .cust2   (cust2_i),
        .data    (data_i),
        .cur_bit (cur_bit)
    );

    irfe_seq #(
        .LEAD_T   (LEAD_T),
        .LSP_T    (LSP_T),
        .RSP_T    (RSP_T),
        .MARK_T   (MARK_T),
        .SP0_T    (SP0_T),
        .SP1_T    (SP1_T),
        .PERIOD_T (PERIOD_T),
        .NBITS    (NBITS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start_i),
        .key_held (key_held_i),
        .cur_bit  (cur_bit),
        .mark     (mark_o),
        .busy     (busy_o),
        .load     (load),
        .shift    (shift)
    );

endmodule

// File: rtl/irfe_encoder_chk.sv
// Checker for the IR frame encoder's port behaviour; bound to every instance.
// Assumes the same timing parameters as the encoder it watches.
module irfe_encoder_chk
    import irfe_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 16_000_000,
    parameter int unsigned TICK_HZ = 16_000
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic key_held_i,
    input logic mark_o,
    input logic busy_o
);

    localparam int unsigned DIV    = CLK_HZ / TICK_HZ;
    localparam int unsigned LEAD_C = us_to_ticks(LEAD_MARK_US, TICK_HZ) * DIV;
    localparam int unsigned MARK_C = us_to_ticks(MARK_US, TICK_HZ) * DIV;

    logic [31:0] mark_run;

    // Length of the current run of high mark cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark_run <= '0;
        end else if (mark_o) begin
            mark_run <= mark_run + 1'b1;
        end else begin
            mark_run <= '0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!mark_o && !busy_o));

    // R8
    mark_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark_o |-> busy_o);

    // R8
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R7
    release_needs_key_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !$past(key_held_i));

    // R4
    mark_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mark_o) |-> (mark_run == LEAD_C || mark_run == MARK_C));

endmodule

bind irfe_encoder irfe_encoder_chk #(
    .CLK_HZ  (CLK_HZ),
    .TICK_HZ (TICK_HZ)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .key_held_i (key_held_i),
    .mark_o     (mark_o),
    .busy_o     (busy_o)
);

// File: tb/sim_irfe_encoder.sv
// Bench for the IR frame encoder: directed and seeded random frames.
module sim_irfe_encoder;

    // Two clock cycles per tick, 16 ticks per ms; tick counts rounded from ms.
    localparam int unsigned TICK_HZ = 16000;
    localparam int unsigned DIV     = 2;
    localparam int unsigned CLK_HZ  = TICK_HZ * DIV;
    localparam int T_LEAD = 144;
    localparam int T_LSP  = 72;
    localparam int T_RSP  = 36;
    localparam int T_MARK = 9;
    localparam int T_SP0  = 9;
    localparam int T_SP1  = 27;
    localparam int T_PER  = 1728;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       held = 1'b0;
    logic [7:0] c1 = '0, c2 = '0, d = '0;
    logic       mark0, busy0, mark1, busy1;
    int         tests = 0;
    int         fails = 0;
    int unsigned cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irfe_encoder #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .BYTE_W(8), .SECOND_FROM_INPUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .key_held_i(held),
        .cust_i(c1), .cust2_i(c2), .data_i(d), .mark_o(mark0), .busy_o(busy0));

    irfe_encoder #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .BYTE_W(8), .SECOND_FROM_INPUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .key_held_i(held),
        .cust_i(c1), .cust2_i(c2), .data_i(d), .mark_o(mark1), .busy_o(busy1));

    function automatic logic [31:0] exp_bits(input logic [7:0] cc, input logic [7:0] cs,
                                             input logic [7:0] dd, input bit own);
        return {~dd, dd, (own ? cs : ~cc), cc};
    endfunction

    function automatic logic mk(input int w);
        return (w == 0) ? mark0 : mark1;
    endfunction

    task automatic chk_eq(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_len(input int w, input logic lvl, output int n);
        n = 0;
        while (mk(w) == lvl && n < 200000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Measure one whole frame starting at its first high sample.
    task automatic check_frame(input int w, input bit rpt, input logic [31:0] bits);
        int n;
        run_len(w, 1'b1, n);
        chk_eq(rpt ? "R6 repeat mark" : "R2 leader mark", n, T_LEAD * DIV);
        run_len(w, 1'b0, n);
        chk_eq(rpt ? "R6 repeat space" : "R2 leader space", n, (rpt ? T_RSP : T_LSP) * DIV);
        if (!rpt) begin
            for (int i = 0; i < 32; i++) begin
                run_len(w, 1'b1, n);
                chk_eq("R4 bit mark", n, T_MARK * DIV);
                run_len(w, 1'b0, n);
                chk_eq((w == 1) ? "R9 bit space" : "R3 bit space", n, (bits[i] ? T_SP1 : T_SP0) * DIV);
            end
        end
        run_len(w, 1'b1, n);
        chk_eq("R5 stop mark", n, T_MARK * DIV);
    endtask

    task automatic scenario(input logic [7:0] cc, input logic [7:0] cs, input logic [7:0] dd, input int reps);
        int unsigned t0;
        int n;
        logic [31:0] b0, b1;
        b0 = exp_bits(cc, cs, dd, 1'b1);
        b1 = exp_bits(cc, cs, dd, 1'b0);
        c1 = cc; c2 = cs; d = dd;
        held = (reps > 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R8 busy after start", busy0, 1);
        chk_eq("R2 mark after start", mark0, 1);
        t0 = cyc;
        fork
            check_frame(0, 1'b0, b0);
            check_frame(1, 1'b0, b1);
            begin
                // R8: new bytes and a start strobe mid-frame must be ignored
                repeat (400) @(negedge clk);
                c1 = ~cc; c2 = ~cs; d = ~dd;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        for (int r = 1; r <= reps; r++) begin
            n = 0;
            while (!mark0 && n < 20000) begin
                n++;
                @(negedge clk);
            end
            chk_eq("R6 repeat cadence", cyc - t0, T_PER * DIV);
            t0 = cyc;
            if (r == reps) held = 1'b0;
            check_frame(0, 1'b1, '0);
        end
        n = 0;
        while (busy0 && n < 20000) begin
            n++;
            @(negedge clk);
        end
        chk_eq("R7 busy release boundary", cyc - t0, T_PER * DIV);
        repeat (20) @(negedge clk);
        chk_eq("R7 idle mark after release", mark0, 0);
        chk_eq("R7 idle busy after release", busy0, 0);
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        chk_eq("R1 mark in reset", mark0, 0);
        chk_eq("R1 busy in reset", busy0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 mark after reset", mark0, 0);
        chk_eq("R1 busy after reset", busy0, 0);
        scenario(8'h00, 8'h00, 8'h00, 0);
        scenario(8'hFF, 8'hFF, 8'hFF, 1);
        scenario(8'hA5, 8'h3C, 8'h0F, 2);
        for (int k = 0; k < 5; k++) begin
            scenario(8'($urandom), 8'($urandom), 8'($urandom), int'($urandom_range(0, 2)));
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule